// File: doc/BRIEF.md
# Chained Descriptor Block-Read DMA Controller

This block copies data from a backplane address space into host physical memory without processor involvement. Software places a linked list of transfer descriptors in memory, drives the address of the first one on `head_addr` and pulses `start`. From then on the controller works on its own. It fetches a descriptor, issues the backplane read cycles that the descriptor asks for through an abstract bus-cycle request port, and writes every returned word to memory through a memory write port. It then follows the link to the next descriptor. The whole list counts as one transaction. Completion is shown by a `done` flag that can be polled, and by an optional one-cycle interrupt pulse.

Each descriptor occupies five consecutive 32-bit words, in this order: source bus address, cycle-type word, destination memory address, byte count, and link word. Bit 0 of the link word is the end marker. A cycle-type word equal to 0x08 selects the 64-bit block mode. In that mode the address is presented only on the first beat, every beat moves 8 bytes, and the bus stays held between beats. Any other value gives ordinary 32-bit single cycles that carry the address every time. A bus error stops the chain and records which descriptor failed.

Top module: `chain_dma`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `irq`, `mrd_req`, `bc_req` and `mw_req` are all 0.
- R2: Each descriptor is fetched as five memory reads at the descriptor address plus 0, 4, 8, 12 and 16, issued in that order. The words are read as source, cycle type, destination, byte count and link.
- R3: When the cycle-type word is not 0x08, the segment issues one bus cycle per 4 bytes. Every cycle has `bc_addr_phase`=1 and `bc_lock`=0, and `bc_am` equals bits [5:0] of the cycle-type word. Source and destination advance by 4 after each beat. Each write has `mw_wide`=0 and carries `{32'h0, bc_data[31:0]}`.
- R4: When the cycle-type word equals 0x08, every beat moves 8 bytes and addresses advance by 8. `bc_addr_phase` is 1 only on the first beat of the segment, `bc_lock` is 1 on every beat, and each write has `mw_wide`=1 and carries the full 64-bit `bc_data`.
- R5: A segment ends on the beat where the remaining byte count is at most the beat size. If bit 0 of the link word is 0, the next descriptor is fetched at the link word with bit 0 cleared. If bit 0 is 1, the chain ends after this segment.
- R6: When the last segment of a chain completes, `done` becomes 1 and `busy` 0. No memory write or bus cycle occurs after that.
- R7: At chain completion `irq` pulses high for exactly one cycle if `irq_en` is 1. If `irq_en` is 0 it stays 0.
- R8: A bus error (`bc_berr`) stops the chain. The failing beat is not written to memory. `err` becomes 1, `fail_desc` holds the address of the failing descriptor, and `done` stays 0.
- R9: A descriptor with byte count 0 issues no bus cycle and no memory write, and the chain continues with its link.
- R10: A `start` pulse while `busy` is 1 is ignored. The running chain completes with unchanged bus and memory traffic.
- R11: A `start` accepted while idle clears `done` and `err` on the same edge that raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Go pulse; accepted only while idle |
| head_addr | input | 32 | Address of the first descriptor |
| irq_en | input | 1 | Enables the completion interrupt pulse |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | Last chain completed without error |
| err | output | 1 | Last chain stopped on a bus error |
| fail_desc | output | 32 | Address of the descriptor whose beat failed |
| irq | output | 1 | One-cycle completion interrupt |
| mrd_req | output | 1 | Descriptor word read request, held until acknowledged |
| mrd_addr | output | 32 | Descriptor word address |
| mrd_ack | input | 1 | Read acknowledge with data |
| mrd_data | input | 32 | Descriptor word |
| bc_req | output | 1 | Bus read cycle request, held until ack or error |
| bc_addr | output | 32 | Current beat source address |
| bc_am | output | 6 | Cycle-type code for the bus |
| bc_addr_phase | output | 1 | Address must be driven on the bus for this beat |
| bc_lock | output | 1 | Keep bus ownership (no re-arbitration) |
| bc_ack | input | 1 | Beat completed with data |
| bc_berr | input | 1 | Beat ended with bus error |
| bc_data | input | 64 | Beat data (lower 32 bits in single mode) |
| mw_req | output | 1 | Memory write request, held until acknowledged |
| mw_addr | output | 32 | Destination address |
| mw_data | output | 64 | Write data |
| mw_wide | output | 1 | 1 for an 8-byte write, 0 for a 4-byte write |
| mw_ack | input | 1 | Write accepted |

## Verification
All three handshake ports hold their request until a one-cycle acknowledge. An acknowledge seen on one edge moves the design on at that edge, so the next request appears in the following cycle. The bench responders drive acknowledges on falling edges and log each transfer there, which puts every beat's address, phase, lock and data in a per-transfer log. `busy` rises on the edge that samples `start`, and `done` or `err` rises two edges after the final write or the error is accepted. The bench samples flags on the falling edge after the `start` edge and again once `busy` has fallen, and counts `irq` at every falling edge so that a pulse longer or shorter than one cycle is caught.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W     = 32;
  localparam int BEAT_W     = 64;
  localparam int DESC_WORDS = 5;
  localparam logic [31:0] BLOCK_CODE = 32'h0000_0008;

  typedef enum logic [2:0] {E_IDLE, E_BUS, E_WR, E_FIN, E_ERR} eng_state_t;
  typedef enum logic [1:0] {C_IDLE, C_LOAD, C_RUN} chain_state_t;

  function automatic logic is_block(input logic [31:0] type_word);
    return type_word == BLOCK_CODE;
  endfunction

  function automatic logic [ADDR_W-1:0] beat_step(input logic [31:0] type_word);
    return is_block(type_word) ? ADDR_W'(8) : ADDR_W'(4);
  endfunction

  function automatic logic is_last_beat(input logic [ADDR_W-1:0] remaining,
                                        input logic [ADDR_W-1:0] step);
    return remaining <= step;
  endfunction

  function automatic logic link_is_end(input logic [31:0] link);
    return link[0];
  endfunction

  function automatic logic [ADDR_W-1:0] link_target(input logic [31:0] link);
    return {link[31:1], 1'b0};
  endfunction
endpackage

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
  import dma_pkg::*;
#(
  parameter int WORDS = DESC_WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [ADDR_W-1:0]            base,
  output logic                         mrd_req,
  output logic [ADDR_W-1:0]            mrd_addr,
  input  logic                         mrd_ack,
  input  logic [31:0]                  mrd_data,
  output logic                         loaded,
  output logic [WORDS-1:0][31:0]       words
);
  localparam int IDX_W = $clog2(WORDS);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic              word_taken;

  assign mrd_req    = active;
  assign mrd_addr   = base_q + (ADDR_W'(idx) << 2);
  assign word_taken = active && mrd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base_q <= '0;
      loaded <= 1'b0;
    end else begin
      loaded <= 1'b0;
      if (load && !active) begin
        active <= 1'b1;
        idx    <= '0;
        base_q <= base;
      end else if (word_taken) begin
        if (idx == IDX_W'(WORDS - 1)) begin
          active <= 1'b0;
          loaded <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (word_taken && idx == IDX_W'(g)) words[g] <= mrd_data;
    end
  end

  // R2: a pending read keeps its address until acknowledged
  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr));

  // R2: consecutive descriptor words are read at ascending word addresses
  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_taken && idx != IDX_W'(WORDS - 1) |=> mrd_req && mrd_addr == $past(mrd_addr) + ADDR_W'(4));
endmodule

// File: rtl/dma_seg_engine.sv
module dma_seg_engine
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] src,
  input  logic [31:0]       type_word,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] count,
  output logic              bc_req,
  output logic [ADDR_W-1:0] bc_addr,
  output logic [5:0]        bc_am,
  output logic              bc_addr_phase,
  output logic              bc_lock,
  input  logic              bc_ack,
  input  logic              bc_berr,
  input  logic [BEAT_W-1:0] bc_data,
  output logic              mw_req,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [BEAT_W-1:0] mw_data,
  output logic              mw_wide,
  input  logic              mw_ack,
  output logic              seg_done,
  output logic              seg_err
);
  eng_state_t        st;
  logic [ADDR_W-1:0] src_q, dst_q, rem_q;
  logic [31:0]       type_q;
  logic              first_q;
  logic [BEAT_W-1:0] data_q;

  // named internal events
  logic              blk;
  logic [ADDR_W-1:0] step;
  logic              last_beat;
  logic              bus_fault;
  logic              beat_taken;
  logic              beat_written;

  assign blk          = is_block(type_q);
  assign step         = beat_step(type_q);
  assign last_beat    = is_last_beat(rem_q, step);
  assign bus_fault    = (st == E_BUS) && bc_berr;
  assign beat_taken   = (st == E_BUS) && bc_ack && !bc_berr;
  assign beat_written = (st == E_WR) && mw_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      type_q  <= '0;
      first_q <= 1'b0;
      data_q  <= '0;
    end else begin
      unique case (st)
        E_IDLE: if (run) begin
          src_q   <= src;
          dst_q   <= dst;
          rem_q   <= count;
          type_q  <= type_word;
          first_q <= 1'b1;
          st      <= (count == '0) ? E_FIN : E_BUS;
        end
        E_BUS: begin
          if (bus_fault) begin
            st <= E_ERR;
          end else if (beat_taken) begin
            data_q  <= blk ? bc_data : {32'h0, bc_data[31:0]};
            first_q <= 1'b0;
            st      <= E_WR;
          end
        end
        E_WR: if (beat_written) begin
          if (last_beat) begin
            st <= E_FIN;
          end else begin
            src_q <= src_q + step;
            dst_q <= dst_q + step;
            rem_q <= rem_q - step;
            st    <= E_BUS;
          end
        end
        E_FIN, E_ERR: st <= E_IDLE;
        default:      st <= E_IDLE;
      endcase
    end
  end

  assign bc_req        = (st == E_BUS);
  assign bc_addr       = src_q;
  assign bc_am         = type_q[5:0];
  assign bc_addr_phase = !blk || first_q;
  assign bc_lock       = blk && (st == E_BUS || st == E_WR);
  assign mw_req        = (st == E_WR);
  assign mw_addr       = dst_q;
  assign mw_data       = data_q;
  assign mw_wide       = blk;
  assign seg_done      = (st == E_FIN);
  assign seg_err       = (st == E_ERR);

  // R3: a pending bus cycle keeps address and type until it ends
  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bc_req && !bc_ack && !bc_berr |=> bc_req && $stable(bc_addr) && $stable(bc_am));

  // R3/R4: source advances by one beat size between beats
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_written && !last_beat |=> bc_req && bc_addr == $past(bc_addr) + $past(step));

  // R4: later block beats keep the bus and carry no address phase
  assert_block_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_written && blk && !last_beat |=> bc_lock && !bc_addr_phase);

  // R8: a faulted beat is never written
  assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> !mw_req && seg_err);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] head_addr,
  input  logic        irq_en,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] fail_desc,
  output logic        irq,
  output logic        mrd_req,
  output logic [31:0] mrd_addr,
  input  logic        mrd_ack,
  input  logic [31:0] mrd_data,
  output logic        bc_req,
  output logic [31:0] bc_addr,
  output logic [5:0]  bc_am,
  output logic        bc_addr_phase,
  output logic        bc_lock,
  input  logic        bc_ack,
  input  logic        bc_berr,
  input  logic [63:0] bc_data,
  output logic        mw_req,
  output logic [31:0] mw_addr,
  output logic [63:0] mw_data,
  output logic        mw_wide,
  input  logic        mw_ack
);
  chain_state_t                cst;
  logic [ADDR_W-1:0]           desc_ptr;
  logic                        load_q;
  logic                        loaded;
  logic [DESC_WORDS-1:0][31:0] words;
  logic                        seg_done, seg_err;
  logic                        chain_end;

  dma_desc_loader #(.WORDS(DESC_WORDS)) u_loader (
    .clk(clk), .rst_n(rst_n), .load(load_q), .base(desc_ptr),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
    .loaded(loaded), .words(words)
  );

  dma_seg_engine u_engine (
    .clk(clk), .rst_n(rst_n), .run(loaded),
    .src(words[0]), .type_word(words[1]), .dst(words[2]), .count(words[3]),
    .bc_req(bc_req), .bc_addr(bc_addr), .bc_am(bc_am), .bc_addr_phase(bc_addr_phase),
    .bc_lock(bc_lock), .bc_ack(bc_ack), .bc_berr(bc_berr), .bc_data(bc_data),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_wide(mw_wide),
    .mw_ack(mw_ack), .seg_done(seg_done), .seg_err(seg_err)
  );

  assign chain_end = link_is_end(words[4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst       <= C_IDLE;
      desc_ptr  <= '0;
      load_q    <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      fail_desc <= '0;
      irq       <= 1'b0;
    end else begin
      load_q <= 1'b0;
      irq    <= 1'b0;
      unique case (cst)
        C_IDLE: if (start) begin
          desc_ptr <= head_addr;
          done     <= 1'b0;
          err      <= 1'b0;
          load_q   <= 1'b1;
          cst      <= C_LOAD;
        end
        C_LOAD: if (loaded) cst <= C_RUN;
        C_RUN: begin
          if (seg_err) begin
            err       <= 1'b1;
            fail_desc <= desc_ptr;
            cst       <= C_IDLE;
          end else if (seg_done) begin
            if (chain_end) begin
              done <= 1'b1;
              irq  <= irq_en;
              cst  <= C_IDLE;
            end else begin
              desc_ptr <= link_target(words[4]);
              load_q   <= 1'b1;
              cst      <= C_LOAD;
            end
          end
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  assign busy = (cst != C_IDLE);

  // R8: a chain never finishes both successfully and with an error
  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R7: the interrupt is a single-cycle pulse
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: an interrupt only accompanies successful completion
  assert_irq_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done && !busy);

  // R6: no traffic once the controller is idle
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mrd_req && !bc_req && !mw_req);
endmodule

// File: tb/chain_dma_bench.sv
`timescale 1ns/1ps
module chain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] head_addr = '0;
  logic        irq_en = 1'b0;
  logic        busy, done, err, irq;
  logic [31:0] fail_desc;
  logic        mrd_req, mrd_ack = 1'b0;
  logic [31:0] mrd_addr, mrd_data = '0;
  logic        bc_req, bc_addr_phase, bc_lock, bc_ack = 1'b0, bc_berr = 1'b0;
  logic [31:0] bc_addr;
  logic [5:0]  bc_am;
  logic [63:0] bc_data = '0;
  logic        mw_req, mw_wide, mw_ack = 1'b0;
  logic [31:0] mw_addr;
  logic [63:0] mw_data;

  always #2 clk = ~clk;

  chain_dma u_chain_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr), .irq_en(irq_en),
    .busy(busy), .done(done), .err(err), .fail_desc(fail_desc), .irq(irq),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
    .bc_req(bc_req), .bc_addr(bc_addr), .bc_am(bc_am), .bc_addr_phase(bc_addr_phase),
    .bc_lock(bc_lock), .bc_ack(bc_ack), .bc_berr(bc_berr), .bc_data(bc_data),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_wide(mw_wide), .mw_ack(mw_ack)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:255];
  logic [31:0] fetch_log [0:63];
  logic [31:0] bus_addr_log [0:63];
  logic [5:0]  bus_am_log [0:63];
  logic        bus_phase_log [0:63];
  logic        bus_lock_log [0:63];
  logic [31:0] wr_addr_log [0:63];
  logic [63:0] wr_data_log [0:63];
  logic        wr_wide_log [0:63];
  int fetch_n = 0, bus_n = 0, wr_n = 0, irq_cnt = 0;
  bit          berr_en = 1'b0;
  logic [31:0] berr_at = '0;

  function automatic logic [63:0] slave_drive(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_5A5A};
  endfunction

  function automatic logic [63:0] expect_write(input logic [31:0] a, input bit wide);
    return wide ? {~a, a ^ 32'h5A5A_5A5A} : {32'h0, a ^ 32'h5A5A_5A5A};
  endfunction

  always @(negedge clk) begin
    mrd_ack <= 1'b0;
    bc_ack  <= 1'b0;
    bc_berr <= 1'b0;
    mw_ack  <= 1'b0;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mrd_req && !mrd_ack) begin
      mrd_ack  <= 1'b1;
      mrd_data <= mem[mrd_addr[9:2]];
      if (fetch_n < 64) fetch_log[fetch_n] <= mrd_addr;
      fetch_n <= fetch_n + 1;
    end
    if (bc_req && !bc_ack && !bc_berr) begin
      if (berr_en && bc_addr == berr_at) begin
        bc_berr <= 1'b1;
      end else begin
        bc_ack  <= 1'b1;
        bc_data <= slave_drive(bc_addr);
        if (bus_n < 64) begin
          bus_addr_log[bus_n]  <= bc_addr;
          bus_am_log[bus_n]    <= bc_am;
          bus_phase_log[bus_n] <= bc_addr_phase;
          bus_lock_log[bus_n]  <= bc_lock;
        end
        bus_n <= bus_n + 1;
      end
    end
    if (mw_req && !mw_ack) begin
      mw_ack <= 1'b1;
      if (wr_n < 64) begin
        wr_addr_log[wr_n] <= mw_addr;
        wr_data_log[wr_n] <= mw_data;
        wr_wide_log[wr_n] <= mw_wide;
      end
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] src, input logic [31:0] typ,
                          input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] link);
    mem[at[9:2]]       = src;
    mem[at[9:2] + 8'd1] = typ;
    mem[at[9:2] + 8'd2] = dst;
    mem[at[9:2] + 8'd3] = cnt;
    mem[at[9:2] + 8'd4] = link;
  endtask

  task automatic clear_logs();
    fetch_n = 0; bus_n = 0; wr_n = 0; irq_cnt = 0;
  endtask

  task automatic pulse_start(input logic [31:0] head);
    @(negedge clk);
    head_addr = head;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // checks a run of beats against the bench's own model of a segment
  task automatic chk_seg(input string tag, input int first_idx, input int nbeats,
                         input logic [31:0] src, input logic [31:0] dst, input bit wide,
                         input logic [5:0] am);
    for (int b = 0; b < nbeats; b++) begin
      automatic logic [31:0] s = src + (wide ? 32'(8*b) : 32'(4*b));
      automatic logic [31:0] d = dst + (wide ? 32'(8*b) : 32'(4*b));
      chk({tag, " bus addr"}, 64'(bus_addr_log[first_idx+b]), 64'(s));
      chk({tag, " bus am"}, 64'(bus_am_log[first_idx+b]), 64'(am));
      chk({tag, " addr phase"}, 64'(bus_phase_log[first_idx+b]), 64'(!wide || b == 0));
      chk({tag, " lock"}, 64'(bus_lock_log[first_idx+b]), 64'(wide));
      chk({tag, " wr addr"}, 64'(wr_addr_log[first_idx+b]), 64'(d));
      chk({tag, " wr data"}, wr_data_log[first_idx+b], expect_write(s, wide));
      chk({tag, " wr wide"}, 64'(wr_wide_log[first_idx+b]), 64'(wide));
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
    chk("R1 err", 64'(err), 64'(0));
    chk("R1 irq", 64'(irq), 64'(0));
    chk("R1 requests", 64'({mrd_req, bc_req, mw_req}), 64'(0));
  endtask

  task automatic t_single();
    put_desc(32'h100, 32'h0010_0000, 32'h09, 32'h2000_0000, 32'd12, 32'h1);
    clear_logs();
    irq_en = 1'b1;
    pulse_start(32'h100);
    chk("R11 busy after start", 64'(busy), 64'(1));
    wait_idle();
    chk("R2 fetch count", 64'(fetch_n), 64'(5));
    for (int k = 0; k < 5; k++) chk("R2 fetch addr", 64'(fetch_log[k]), 64'(32'h100 + 32'(4*k)));
    chk("R3 beat count", 64'(wr_n), 64'(3));
    chk("R3 bus count", 64'(bus_n), 64'(3));
    chk_seg("R3 single", 0, 3, 32'h0010_0000, 32'h2000_0000, 1'b0, 6'h09);
    chk("R6 done", 64'(done), 64'(1));
    chk("R6 err", 64'(err), 64'(0));
    chk("R7 irq pulses", 64'(irq_cnt), 64'(1));
  endtask

  task automatic t_block();
    put_desc(32'h120, 32'h0020_0000, 32'h08, 32'h2080_0000, 32'd24, 32'h3);
    clear_logs();
    irq_en = 1'b1;
    pulse_start(32'h120);
    wait_idle();
    chk("R4 beat count", 64'(wr_n), 64'(3));
    chk_seg("R4 block", 0, 3, 32'h0020_0000, 32'h2080_0000, 1'b1, 6'h08);
    chk("R5 end marker stops chain", 64'(fetch_n), 64'(5));
    chk("R6 done block", 64'(done), 64'(1));
  endtask

  task automatic setup_chain();
    put_desc(32'h140, 32'h0050_0000, 32'h09, 32'h2300_0000, 32'd8,  32'h160);
    put_desc(32'h160, 32'h0070_0000, 32'h09, 32'h2500_0000, 32'd0,  32'h180);
    put_desc(32'h180, 32'h0060_0000, 32'h08, 32'h2400_0000, 32'd16, 32'h1);
  endtask

  task automatic chk_chain(input string tag);
    chk({tag, " fetch count"}, 64'(fetch_n), 64'(15));
    chk({tag, " link fetch"}, 64'(fetch_log[5]), 64'(32'h160));
    chk({tag, " link fetch 2"}, 64'(fetch_log[10]), 64'(32'h180));
    chk({tag, " writes"}, 64'(wr_n), 64'(4));
    chk({tag, " bus cycles"}, 64'(bus_n), 64'(4));
    chk_seg({tag, " seg1"}, 0, 2, 32'h0050_0000, 32'h2300_0000, 1'b0, 6'h09);
    chk_seg({tag, " seg3"}, 2, 2, 32'h0060_0000, 32'h2400_0000, 1'b1, 6'h08);
    chk({tag, " done"}, 64'(done), 64'(1));
  endtask

  task automatic t_chain();
    setup_chain();
    clear_logs();
    irq_en = 1'b0;
    pulse_start(32'h140);
    wait_idle();
    chk_chain("R5 R9 chain");
    chk("R7 irq masked", 64'(irq_cnt), 64'(0));
  endtask

  task automatic t_berr();
    put_desc(32'h200, 32'h0030_0000, 32'h09, 32'h2100_0000, 32'd8,  32'h240);
    put_desc(32'h240, 32'h0040_0000, 32'h08, 32'h2200_0000, 32'd32, 32'h1);
    clear_logs();
    irq_en = 1'b1;
    berr_en = 1'b1;
    berr_at = 32'h0040_0008;
    pulse_start(32'h200);
    wait_idle();
    berr_en = 1'b0;
    chk("R8 err", 64'(err), 64'(1));
    chk("R8 done stays low", 64'(done), 64'(0));
    chk("R8 fail desc", 64'(fail_desc), 64'(32'h240));
    chk("R8 writes before fault", 64'(wr_n), 64'(3));
    chk("R8 last write addr", 64'(wr_addr_log[2]), 64'(32'h2200_0000));
    chk("R8 no irq", 64'(irq_cnt), 64'(0));
    repeat (10) @(negedge clk);
    chk("R8 no later writes", 64'(wr_n), 64'(3));
  endtask

  task automatic t_restart_busy();
    setup_chain();
    clear_logs();
    irq_en = 1'b0;
    pulse_start(32'h140);
    chk("R11 err cleared", 64'(err), 64'(0));
    chk("R11 done cleared", 64'(done), 64'(0));
    repeat (4) @(negedge clk);
    chk("R10 busy mid chain", 64'(busy), 64'(1));
    pulse_start(32'h100);
    wait_idle();
    chk_chain("R10 ignored start");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_block();
    t_chain();
    t_berr();
    t_restart_busy();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule